// File: doc/BRIEF.md
# Dual-Decoder Issue Merge Arbiter

The block joins the outputs of two instruction decoders into a single issue FIFO whose rows are 70 bits wide. A decoded instruction can carry up to 133 bits of fields, which is more than one row holds. The block therefore takes one whole instruction at a time and splits it into one, two or three rows, depending on its command type. Every row carries a 3-bit opcode tag in its top bits. The first row of an instruction also carries a start flag, so the downstream issue logic can rebuild the instruction.

A four-state arbiter serves the two decoders in turn. While it waits on one decoder, it either grants that decoder (if the decoder is ready and the FIFO has room) or passes the turn to the other decoder. Once granted, a decoder keeps the grant until its last row has been written, even if the FIFO fills part-way through. On the cycle of that last write, the decoder gets a one-cycle pop acknowledge, and the turn moves to the other decoder. A decoder must hold its ready flag and its fields stable from the moment it raises ready until it sees its pop.

Top module: `dec_merge_arb`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, no row is written and no pop is given. After reset the arbiter first waits on decoder 0.
- R2: When the arbiter is waiting on decoder d, decoder d is ready and `fifo_full_i` is low, the first row of that decoder's instruction is written one cycle later. If decoder d is ready but the FIFO is full, the arbiter keeps waiting on decoder d and does not pass the turn.
- R3: When the arbiter is waiting on decoder d and decoder d is not ready, the turn passes to the other decoder in the next cycle. With only decoder 1 ready after reset, its first row is written two cycles after release.
- R4: `fifo_wr_o` is never high while `fifo_full_i` is high. A full FIFO in the middle of an instruction stalls the writing without releasing the grant. No row is skipped or repeated.
- R5: `dec_pop_o[d]` pulses for exactly one cycle, in the cycle where the last row of decoder d's instruction is written. The next cycle, the arbiter waits on the other decoder.
- R6: Row format: bits [69:67] hold the opcode, bit 66 is the start flag (1 only on an instruction's first row), bits [65:64] are zero, and bits [63:0] hold the payload.
- R7: Search (opcode 1) takes three rows. Their payloads are {cid, site} in bits [36:0] with cid at [36:32], then crc in [63:0], then asis in [31:0].
- R8: Set-attribute (opcode 2) takes two rows. Their payloads are {cid, path, ttl, weight} in bits [57:0] with cid at [57:53] and weight at [15:0], then asis in [31:0].
- R9: Delete (opcode 3) takes one row with payload {cid, asis, path} in bits [57:0], cid at [57:53] and path at [20:0].
- R10: Count-free (opcode 4), init (opcode 5) and any other opcode take one row with payload {cid, asis} in bits [36:0], cid at [36:32].
- R11: When both decoders keep instructions ready, whole instructions alternate between them, starting with decoder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_rdy_i | input | 2 | Per-decoder flag: an instruction is ready |
| dec_op_i | input | 2x3 | Per-decoder opcode |
| dec_cid_i | input | 2x5 | Per-decoder cid field |
| dec_asis_i | input | 2x32 | Per-decoder asis field |
| dec_site_i | input | 2x32 | Per-decoder site field |
| dec_path_i | input | 2x21 | Per-decoder path field |
| dec_ttl_i | input | 2x16 | Per-decoder ttl field |
| dec_weight_i | input | 2x16 | Per-decoder weight field |
| dec_crc_i | input | 2x64 | Per-decoder crc field |
| dec_pop_o | output | 2 | Per-decoder acknowledge: the instruction has been consumed |
| fifo_full_i | input | 1 | Issue FIFO full |
| fifo_wr_o | output | 1 | Issue FIFO write enable |
| fifo_row_o | output | 70 | Issue FIFO write data |

## Verification
Completing an instruction and stalling on a full FIFO can fall in the same cycle. The bench provokes this by raising `fifo_full_i` exactly in the cycle the third search row would be written, while the other decoder is already ready. It judges the result in two ways. First, the pop must arrive only in the cycle when the row actually goes out, and the other decoder must not get in between. Second, the captured row stream must be complete and in order. A second test holds the FIFO full while both decoders are ready during decoder 0's turn, and checks that decoder 0 still goes first.

// File: rtl/dec_merge_pkg.sv
package dec_merge_pkg;
  localparam int ROW_W   = 70;
  localparam int OP_W    = 3;
  localparam int CID_W   = 5;
  localparam int ASIS_W  = 32;
  localparam int SITE_W  = 32;
  localparam int PATH_W  = 21;
  localparam int TTL_W   = 16;
  localparam int WGT_W   = 16;
  localparam int CRC_W   = 64;
  localparam int PAY_W   = 64;
  localparam int PAD_W   = ROW_W - OP_W - 1 - PAY_W;
  localparam int START_BIT = ROW_W - OP_W - 1;
  localparam int ROWS_MAX  = 3;
  localparam int RIDX_W    = $clog2(ROWS_MAX + 1);
  localparam int NUM_DEC   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP        = 3'd0,
    OP_SEARCH     = 3'd1,
    OP_SET_ATTR   = 3'd2,
    OP_DELETE     = 3'd3,
    OP_COUNT_FREE = 3'd4,
    OP_INIT       = 3'd5
  } op_e;

  // bit0 = writing, bit1 = decoder 1 owns the turn
  typedef enum logic [1:0] {
    ST_IDLE0 = 2'b00,
    ST_WR0   = 2'b01,
    ST_IDLE1 = 2'b10,
    ST_WR1   = 2'b11
  } arb_st_e;

  typedef struct packed {
    logic [CID_W-1:0]  cid;
    logic [ASIS_W-1:0] asis;
    logic [SITE_W-1:0] site;
    logic [PATH_W-1:0] path;
    logic [TTL_W-1:0]  ttl;
    logic [WGT_W-1:0]  weight;
    logic [CRC_W-1:0]  crc;
  } fields_t;
endpackage

// File: rtl/dec_row_pack.sv
module dec_row_pack
  import dec_merge_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  fields_t           fld_i,
  input  logic [RIDX_W-1:0] row_idx_i,
  output logic [ROW_W-1:0]  row_o,
  output logic              last_row_o
);
  logic [PAY_W-1:0]  payload;
  logic [RIDX_W-1:0] n_rows;

  always_comb begin
    payload = '0;
    n_rows  = RIDX_W'(1);
    case (op_i)
      OP_SEARCH: begin
        n_rows = RIDX_W'(3);
        case (row_idx_i)
          RIDX_W'(0): payload = PAY_W'({fld_i.cid, fld_i.site});
          RIDX_W'(1): payload = fld_i.crc;
          default:    payload = PAY_W'(fld_i.asis);
        endcase
      end
      OP_SET_ATTR: begin
        n_rows = RIDX_W'(2);
        if (row_idx_i == '0)
          payload = PAY_W'({fld_i.cid, fld_i.path, fld_i.ttl, fld_i.weight});
        else
          payload = PAY_W'(fld_i.asis);
      end
      OP_DELETE: payload = PAY_W'({fld_i.cid, fld_i.asis, fld_i.path});
      default:   payload = PAY_W'({fld_i.cid, fld_i.asis});
    endcase
  end

  assign row_o      = {op_i, (row_idx_i == '0), {PAD_W{1'b0}}, payload};
  assign last_row_o = (row_idx_i == n_rows - RIDX_W'(1));
endmodule

// File: rtl/dec_merge_fsm.sv
module dec_merge_fsm
  import dec_merge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEC-1:0] rdy_i,
  input  logic               fifo_full_i,
  input  logic               last_row_i,
  output logic               sel_o,
  output logic               wr_o,
  output logic [NUM_DEC-1:0] pop_o,
  output logic [RIDX_W-1:0]  row_idx_o
);
  arb_st_e st_q, st_d;
  logic    done;

  assign sel_o = st_q[1];
  assign wr_o  = st_q[0] & ~fifo_full_i;
  assign done  = wr_o & last_row_i;

  always_comb begin
    pop_o        = '0;
    pop_o[sel_o] = done;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE0: if (rdy_i[0] && !fifo_full_i) st_d = ST_WR0;
                else if (!rdy_i[0])           st_d = ST_IDLE1;
      ST_WR0:   if (done)                     st_d = ST_IDLE1;
      ST_IDLE1: if (rdy_i[1] && !fifo_full_i) st_d = ST_WR1;
                else if (!rdy_i[1])           st_d = ST_IDLE0;
      ST_WR1:   if (done)                     st_d = ST_IDLE0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE0;
      row_idx_o <= '0;
    end else begin
      st_q <= st_d;
      if (done)      row_idx_o <= '0;
      else if (wr_o) row_idx_o <= row_idx_o + RIDX_W'(1);
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |-> !wr_o);
  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[0] && fifo_full_i) |=> ($stable(sel_o) && $stable(row_idx_o) && st_q[0]));
  // R5
  pop_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_o) && ((pop_o != '0) -> wr_o));
  // R5
  turn_pass0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o[0] |=> st_q == ST_IDLE1);
  // R5
  turn_pass1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o[1] |=> st_q == ST_IDLE0);
  // R3
  skip_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE0 && !rdy_i[0]) |=> st_q == ST_IDLE1);
  // R2
  wait_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE0 && rdy_i[0] && fifo_full_i) |=> st_q == ST_IDLE0);
endmodule

// File: rtl/dec_merge_arb.sv
module dec_merge_arb
  import dec_merge_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_DEC-1:0]             dec_rdy_i,
  input  logic [NUM_DEC-1:0][OP_W-1:0]   dec_op_i,
  input  logic [NUM_DEC-1:0][CID_W-1:0]  dec_cid_i,
  input  logic [NUM_DEC-1:0][ASIS_W-1:0] dec_asis_i,
  input  logic [NUM_DEC-1:0][SITE_W-1:0] dec_site_i,
  input  logic [NUM_DEC-1:0][PATH_W-1:0] dec_path_i,
  input  logic [NUM_DEC-1:0][TTL_W-1:0]  dec_ttl_i,
  input  logic [NUM_DEC-1:0][WGT_W-1:0]  dec_weight_i,
  input  logic [NUM_DEC-1:0][CRC_W-1:0]  dec_crc_i,
  output logic [NUM_DEC-1:0]             dec_pop_o,
  input  logic                           fifo_full_i,
  output logic                           fifo_wr_o,
  output logic [ROW_W-1:0]               fifo_row_o
);
  fields_t           fld [NUM_DEC];
  logic              sel;
  logic              last_row;
  logic [RIDX_W-1:0] row_idx;

  for (genvar d = 0; d < NUM_DEC; d++) begin : g_fld
    assign fld[d] = '{cid: dec_cid_i[d], asis: dec_asis_i[d], site: dec_site_i[d],
                      path: dec_path_i[d], ttl: dec_ttl_i[d], weight: dec_weight_i[d],
                      crc: dec_crc_i[d]};
  end

  dec_merge_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rdy_i       (dec_rdy_i),
    .fifo_full_i (fifo_full_i),
    .last_row_i  (last_row),
    .sel_o       (sel),
    .wr_o        (fifo_wr_o),
    .pop_o       (dec_pop_o),
    .row_idx_o   (row_idx)
  );

  dec_row_pack i_pack (
    .op_i       (dec_op_i[sel]),
    .fld_i      (fld[sel]),
    .row_idx_i  (row_idx),
    .row_o      (fifo_row_o),
    .last_row_o (last_row)
  );

  // instruction-boundary tracking for checks only
  logic            mid_instr_q;
  logic [OP_W-1:0] tag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_instr_q <= 1'b0;
      tag_q       <= '0;
    end else if (fifo_wr_o) begin
      mid_instr_q <= (dec_pop_o == '0);
      tag_q       <= fifo_row_o[ROW_W-1 -: OP_W];
    end
  end

  // R6
  start_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> (fifo_row_o[START_BIT] == !mid_instr_q));
  // R6
  tag_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && mid_instr_q) |-> (fifo_row_o[ROW_W-1 -: OP_W] == tag_q));
  // R6
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> (fifo_row_o[START_BIT-1 -: PAD_W] == '0));
endmodule

// File: tb/test_dec_merge_arb.sv
module test_dec_merge_arb;
  typedef struct packed {
    logic [2:0] op; logic [4:0] cid; logic [31:0] asis; logic [31:0] site;
    logic [20:0] path; logic [15:0] ttl; logic [15:0] weight; logic [63:0] crc;
  } instr_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] dec_rdy_i;
  logic [1:0][2:0] dec_op_i;
  logic [1:0][4:0] dec_cid_i;
  logic [1:0][31:0] dec_asis_i, dec_site_i;
  logic [1:0][20:0] dec_path_i;
  logic [1:0][15:0] dec_ttl_i, dec_weight_i;
  logic [1:0][63:0] dec_crc_i;
  logic [1:0] dec_pop_o;
  logic fifo_full_i;
  logic fifo_wr_o;
  logic [69:0] fifo_row_o;

  dec_merge_arb i_dec_merge_arb (.*);

  always #5ns clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  instr_t q0[$], q1[$];
  bit full_q[$];
  logic [69:0] got[$], exp_q[$];
  int first_wr, first_pop, pop_cnt0, pop_cnt1, viol;
  int pop_order[$];

  task automatic check(input bit ok, input string req, input logic [69:0] act, input logic [69:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic instr_t mk(input logic [2:0] op, input logic [31:0] s);
    instr_t x;
    x.op = op; x.cid = s[4:0] ^ 5'h15; x.asis = 32'hA500_0000 ^ s;
    x.site = 32'h5100_0000 + s; x.path = 21'h1ABCD ^ s[20:0];
    x.ttl = 16'h7700 + s[15:0]; x.weight = 16'hBEEF ^ s[15:0];
    x.crc = {32'hC0FF_EE00 + s, ~s};
    return x;
  endfunction

  task automatic add_exp(input instr_t x);
    case (x.op)
      3'd1: begin
        exp_q.push_back({x.op, 1'b1, 2'b00, 27'd0, x.cid, x.site});
        exp_q.push_back({x.op, 1'b0, 2'b00, x.crc});
        exp_q.push_back({x.op, 1'b0, 2'b00, 32'd0, x.asis});
      end
      3'd2: begin
        exp_q.push_back({x.op, 1'b1, 2'b00, 6'd0, x.cid, x.path, x.ttl, x.weight});
        exp_q.push_back({x.op, 1'b0, 2'b00, 32'd0, x.asis});
      end
      3'd3: exp_q.push_back({x.op, 1'b1, 2'b00, 6'd0, x.cid, x.asis, x.path});
      default: exp_q.push_back({x.op, 1'b1, 2'b00, 27'd0, x.cid, x.asis});
    endcase
  endtask

  task automatic drive(input int d, input instr_t x);
    dec_op_i[d] = x.op; dec_cid_i[d] = x.cid; dec_asis_i[d] = x.asis;
    dec_site_i[d] = x.site; dec_path_i[d] = x.path; dec_ttl_i[d] = x.ttl;
    dec_weight_i[d] = x.weight; dec_crc_i[d] = x.crc;
  endtask

  task automatic apply_inputs();
    dec_rdy_i = {q1.size() != 0, q0.size() != 0};
    drive(0, (q0.size() != 0) ? q0[0] : '0);
    drive(1, (q1.size() != 0) ? q1[0] : '0);
    fifo_full_i = (full_q.size() != 0) ? full_q.pop_front() : 1'b0;
  endtask

  task automatic start_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    q0.delete(); q1.delete(); full_q.delete(); got.delete(); exp_q.delete(); pop_order.delete();
    first_wr = -1; first_pop = -1; pop_cnt0 = 0; pop_cnt1 = 0; viol = 0;
    apply_inputs();
  endtask

  // inputs set while reset is low; release and step
  task automatic run(input int max_steps);
    int extra = 0;
    apply_inputs();
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < max_steps && extra < 3; k++) begin
      logic [1:0] p;
      #1ns;
      p = dec_pop_o;
      if (fifo_wr_o && fifo_full_i) viol++;
      if (p != 2'b00 && !fifo_wr_o) viol++;
      if (fifo_wr_o) begin
        got.push_back(fifo_row_o);
        if (first_wr < 0) first_wr = k;
      end
      if (p != 2'b00 && first_pop < 0) first_pop = k;
      if (p[0]) begin pop_cnt0++; pop_order.push_back(0); end
      if (p[1]) begin pop_cnt1++; pop_order.push_back(1); end
      @(negedge clk_i);
      if (p[0]) void'(q0.pop_front());
      if (p[1]) void'(q1.pop_front());
      apply_inputs();
      if (q0.size() == 0 && q1.size() == 0) extra++;
    end
  endtask

  task automatic cmp_rows(input string req);
    check(got.size() == exp_q.size(), {req, " row count"}, 70'(got.size()), 70'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check(got[i] === exp_q[i], {req, " row data"}, got[i], exp_q[i]);
    check(viol == 0, "R4 no write when full / pop without write", 70'(viol), 70'd0);
  endtask

  task automatic t_reset();
    instr_t a;
    start_reset();
    a = mk(3'd3, 32'h11);
    q0.push_back(a); q1.push_back(mk(3'd3, 32'h12));
    apply_inputs();
    @(negedge clk_i); #1ns;
    check(fifo_wr_o == 1'b0, "R1 no write in reset", 70'(fifo_wr_o), 70'd0);
    check(dec_pop_o == 2'b00, "R1 no pop in reset", 70'(dec_pop_o), 70'd0);
    add_exp(a); add_exp(q1[0]);
    run(40);
    check(first_wr == 1, "R2 first write one cycle after grant", 70'(first_wr), 70'd1);
    check(pop_order.size() > 0 && pop_order[0] == 0, "R1 decoder 0 served first",
          70'(pop_order.size() > 0 ? pop_order[0] : 9), 70'd0);
    cmp_rows("R9");
  endtask

  task automatic t_search();
    instr_t a;
    start_reset();
    a = mk(3'd1, 32'h2345); q0.push_back(a); add_exp(a);
    run(40);
    cmp_rows("R7");
    check(first_pop == 3, "R5 pop on last search row", 70'(first_pop), 70'd3);
    check(pop_cnt0 == 1 && pop_cnt1 == 0, "R5 single pop", 70'({pop_cnt0[7:0], pop_cnt1[7:0]}), 70'h100);
  endtask

  task automatic t_setattr_skip();
    instr_t a;
    start_reset();
    a = mk(3'd2, 32'hBEE1); q1.push_back(a); add_exp(a);
    run(40);
    check(first_wr == 2, "R3 turn passed to decoder 1", 70'(first_wr), 70'd2);
    cmp_rows("R8");
    check(pop_cnt1 == 1 && first_pop == 3, "R5 pop decoder 1 on row 2", 70'(first_pop), 70'd3);
  endtask

  task automatic t_single_rows();
    instr_t a, b, c, e;
    start_reset();
    a = mk(3'd4, 32'h400); b = mk(3'd5, 32'h500); c = mk(3'd7, 32'h700); e = mk(3'd0, 32'h800);
    q0.push_back(a); q0.push_back(b); q0.push_back(c); q0.push_back(e);
    add_exp(a); add_exp(b); add_exp(c); add_exp(e);
    run(60);
    cmp_rows("R10");
    check(pop_cnt0 == 4, "R10 four pops", 70'(pop_cnt0), 70'd4);
  endtask

  task automatic t_alternate();
    instr_t s0, s1, d0, d1;
    start_reset();
    s0 = mk(3'd1, 32'hA0); s1 = mk(3'd1, 32'hA1); d0 = mk(3'd3, 32'hB0); d1 = mk(3'd2, 32'hB1);
    q0.push_back(s0); q0.push_back(s1); q1.push_back(d0); q1.push_back(d1);
    add_exp(s0); add_exp(d0); add_exp(s1); add_exp(d1);
    run(80);
    cmp_rows("R11");
    check(pop_order.size() == 4, "R11 pop count", 70'(pop_order.size()), 70'd4);
    for (int i = 0; i < pop_order.size(); i++)
      check(pop_order[i] == (i % 2), "R11 alternating owner", 70'(pop_order[i]), 70'(i % 2));
  endtask

  task automatic t_stall();
    instr_t s, d;
    start_reset();
    s = mk(3'd1, 32'h5A5A); d = mk(3'd3, 32'h6B6B);
    q0.push_back(s); q1.push_back(d);
    add_exp(s); add_exp(d);
    // steps: 0 grant, 1 row0, 2 row1, 3-4 full on last row, 5 row2+pop
    full_q = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    run(40);
    cmp_rows("R4");
    check(first_pop == 5, "R4 pop delayed by full on last row", 70'(first_pop), 70'd5);
    check(pop_order.size() == 2 && pop_order[0] == 0, "R5 grant not released in stall",
          70'(pop_order.size() > 0 ? pop_order[0] : 9), 70'd0);
  endtask

  task automatic t_wait_full();
    instr_t a, b;
    start_reset();
    a = mk(3'd4, 32'h77); b = mk(3'd5, 32'h88);
    q0.push_back(a); q1.push_back(b);
    add_exp(a); add_exp(b);
    full_q = '{1'b1, 1'b1, 1'b1, 1'b1};
    run(40);
    check(first_wr == 5, "R2 waits on full with decoder 0 ready", 70'(first_wr), 70'd5);
    check(pop_order.size() > 0 && pop_order[0] == 0, "R2 decoder 0 keeps turn while full",
          70'(pop_order.size() > 0 ? pop_order[0] : 9), 70'd0);
    cmp_rows("R6");
  endtask

  initial begin
    t_reset();
    t_search();
    t_setattr_skip();
    t_single_rows();
    t_alternate();
    t_stall();
    t_wait_full();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%h exp=%h", 70'd1, 70'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule